// File: doc/BRIEF.md
# Transmit CRC-32 Inserter with End-of-Frame Disparity Correction

This block sits on the transmit path, ahead of an 8b/10b encoder. It takes one byte per cycle. Each byte carries a flag that marks it as a control (K) character. The block computes a CRC-32 over the payload of each packet and places the four CRC bytes directly in front of the packet's closing delimiter. It knows three framing modes. In user mode, side-band strobes mark the first and last bytes. In Fibre Channel mode, start-of-frame and end-of-frame ordered sets mark the packet. In Gigabit Ethernet mode, start and terminate control characters mark the packet, and a fixed-length preamble follows the start character. Delimiters, ordered-set bytes and the Ethernet preamble never enter the CRC.

The encoder reports the current running disparity on `rd_pos_i`. Upstream logic always sends the negative-disparity forms of the end-of-frame set and the idle. When the disparity is positive at the decision point, the block rewrites one data byte so that the link returns to negative disparity after the frame. In Fibre Channel mode that byte is the second byte of the end-of-frame set. In Ethernet mode it is the second byte of the first idle after the packet.

A single state machine controls the block. Its states are:
- `ST_IDLE`: between packets.
- `ST_FCSOF`: checks the second byte of a possible start-of-frame.
- `ST_HDR`: skips the bytes that are excluded from the CRC.
- `ST_BODY`: covered payload.
- `ST_CRC`: sends the four CRC bytes, then the held delimiter.
- `ST_EOFX`: the rest of the Fibre Channel end-of-frame.
- `ST_XIDLE`: waits for the first Ethernet idle.
- `ST_XIDLE2`: the second byte of that idle.

Its transitions are:
- IDLE→BODY: a user-mode start strobe.
- IDLE→FCSOF: K28.5 in Fibre Channel mode.
- IDLE→HDR: K27.7 in Ethernet mode.
- FCSOF→HDR: D21.5 follows.
- FCSOF→IDLE: any other byte.
- HDR→BODY: the last skipped byte.
- BODY→CRC: the closing delimiter is accepted.
- CRC→EOFX: Fibre Channel.
- CRC→XIDLE: Ethernet.
- CRC→IDLE: user mode.
- EOFX→IDLE: after three bytes.
- XIDLE→XIDLE2: K28.5.
- XIDLE2→IDLE: the next byte.

Top module: `crcins_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_k` hold their values. The CRC register changes only on a cycle in which an input byte is accepted. The byte order is preserved under any back-pressure.
- R3: The CRC uses the reflected CRC-32 with polynomial 0x04C11DB7. The register starts at all ones and the final value is inverted. It is sent as four bytes with `out_k`=0, least significant byte first, directly before the closing delimiter. `in_ready` stays 0 while the CRC bytes and the held delimiter are being emitted.
- R4: `mode_i`=0 (and 3) selects user mode. The byte with `in_sop`=1 opens a packet and the byte with `in_eop`=1 closes it. Both pass through unchanged and are left out of the CRC. The bytes between them are covered.
- R5: `mode_i`=1 selects Fibre Channel mode. A start-of-frame is 0xBC with k=1 followed by 0xB5 with k=0. Its four bytes are not covered. A K28.5 whose next byte is anything else, such as an idle set, passes through and opens no packet. Inside a packet, 0xBC with k=1 begins the end-of-frame set, which is not covered.
- R6: Fibre Channel fixup. If `rd_pos_i` is 1 when the end-of-frame K28.5 enters the output register, the next byte is rewritten: 0x95 becomes 0xB5 and 0x8A becomes 0xAA. Otherwise it passes unchanged. Bytes three and four always pass unchanged.
- R7: `mode_i`=2 selects Ethernet mode. A packet starts at 0xFB with k=1, and the next PRE_LEN (default 7) bytes are not covered. 0xFD with k=1 ends the packet. Bytes after it, such as extension characters (0xF7, k=1), pass through unchanged and uncovered.
- R8: Ethernet fixup. If `rd_pos_i` is 1 when the first 0xBC (k=1) after the packet is accepted, a following 0x50 (k=0) becomes 0xC5. Later idles pass unchanged.
- R9: `mode_i` is sampled only when a packet starts. A change during a packet has no effect on that packet.
- R10: A byte accepted at one clock edge, other than a closing delimiter, is on the output at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Framing mode: 0 user, 1 Fibre Channel, 2 Ethernet, 3 user |
| rd_pos_i | input | 1 | Encoder running disparity is positive |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_k | input | 1 | Input byte is a control character |
| in_sop | input | 1 | User mode: byte opens a packet |
| in_eop | input | 1 | User mode: byte closes a packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Encoder takes the output byte |
| out_data | output | 8 | Output byte |
| out_k | output | 1 | Output byte is a control character |

## Verification
The assertions check on every cycle that the output holds its value under back-pressure and that the CRC register stays still when no byte is accepted. They also check that input is refused during insertion, that the latched mode stays fixed within a packet, and that an idle-state byte appears one cycle after it is accepted. The bench's reference model covers what needs packet-level context. That includes the CRC values, including the check value of the nine ASCII digits, and the exclusion of delimiters and preamble. It also covers the choice between rewriting and leaving the end-of-frame and idle bytes, the rejection of a K28.5 that is not followed by D21.5, and the mode change in mid-packet.

// File: rtl/crcins_pkg.sv
package crcins_pkg;

    localparam logic [1:0] MODE_USER = 2'd0;
    localparam logic [1:0] MODE_FC   = 2'd1;
    localparam logic [1:0] MODE_GBE  = 2'd2;

    localparam logic [7:0] K28_5 = 8'hBC;
    localparam logic [7:0] K27_7 = 8'hFB;
    localparam logic [7:0] K29_7 = 8'hFD;
    localparam logic [7:0] D21_4 = 8'h95;
    localparam logic [7:0] D21_5 = 8'hB5;
    localparam logic [7:0] D10_4 = 8'h8A;
    localparam logic [7:0] D10_5 = 8'hAA;
    localparam logic [7:0] D16_2 = 8'h50;
    localparam logic [7:0] D5_6  = 8'hC5;

    localparam int CRC_BYTES   = 4;
    localparam int FC_SOF_REST = 2;
    localparam int FC_EOF_REST = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FCSOF, ST_HDR, ST_BODY, ST_CRC, ST_EOFX, ST_XIDLE, ST_XIDLE2
    } state_e;

    typedef enum logic [1:0] {FIX_NONE, FIX_EOF, FIX_IDLE} fix_e;

endpackage

// File: rtl/crcins_crc32.sv
module crcins_crc32 #(
    parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '1;
        else if (init) crc_q <= '1;
        else if (en)   crc_q <= step(crc_q, din);
    end
endmodule

// File: rtl/crcins_fixup.sv
module crcins_fixup
    import crcins_pkg::*;
(
    input  logic [7:0] din,
    input  logic       kin,
    input  fix_e       fix,
    input  logic       flip,
    output logic [7:0] dout
);
    always_comb begin
        dout = din;
        if (flip && !kin) begin
            unique case (fix)
                FIX_EOF: begin
                    if (din == D21_4)      dout = D21_5;
                    else if (din == D10_4) dout = D10_5;
                end
                FIX_IDLE: if (din == D16_2) dout = D5_6;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/crcins_top.sv
module crcins_top
    import crcins_pkg::*;
#(
    parameter int          PRE_LEN   = 7,
    parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       rd_pos_i,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_k,
    input  logic       in_sop,
    input  logic       in_eop,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_k
);
    localparam int CNT_W = $clog2(PRE_LEN + CRC_BYTES + 1);
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_BYTES);
    localparam logic [CNT_W-1:0] EOF_LAST = CNT_W'(FC_EOF_REST - 1);

    state_e           st, st_nx;
    logic [1:0]       pkt_mode;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       held_d;
    logic             held_k;
    logic             flip;
    logic [31:0]      crc_q;
    logic [31:0]      crc_inv;
    logic [7:0]       crc_byte;
    logic [7:0]       fix_d;
    fix_e             fix_sel;
    logic             adv, acc, start_det, end_det, crc_init, crc_en;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv && (st != ST_CRC);
    assign acc      = in_valid && in_ready;
    assign crc_inv  = ~crc_q;
    assign crc_byte = 8'(crc_inv >> {cnt[1:0], 3'b000});
    assign crc_init = acc && (st == ST_IDLE) && start_det;
    assign crc_en   = acc && (st == ST_BODY) && !end_det;

    always_comb begin
        case (mode_i)
            MODE_FC:  start_det = in_k && (in_data == K28_5);
            MODE_GBE: start_det = in_k && (in_data == K27_7);
            default:  start_det = in_sop;
        endcase
        case (pkt_mode)
            MODE_FC:  end_det = in_k && (in_data == K28_5);
            MODE_GBE: end_det = in_k && (in_data == K29_7);
            default:  end_det = in_eop;
        endcase
        if (st == ST_EOFX && cnt == '0) fix_sel = FIX_EOF;
        else if (st == ST_XIDLE2)       fix_sel = FIX_IDLE;
        else                            fix_sel = FIX_NONE;
    end

    crcins_crc32 #(.POLY_REFL(POLY_REFL)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
        .din(in_data), .crc_q(crc_q)
    );

    crcins_fixup u_fix (
        .din(in_data), .kin(in_k), .fix(fix_sel), .flip(flip), .dout(fix_d)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (acc && start_det) begin
                if (mode_i == MODE_FC)       st_nx = ST_FCSOF;
                else if (mode_i == MODE_GBE) st_nx = ST_HDR;
                else                         st_nx = ST_BODY;
            end
            ST_FCSOF:  if (acc) st_nx = (!in_k && in_data == D21_5) ? ST_HDR : ST_IDLE;
            ST_HDR:    if (acc && cnt == CNT_W'(1)) st_nx = ST_BODY;
            ST_BODY:   if (acc && end_det) st_nx = ST_CRC;
            ST_CRC: if (adv && cnt == CRC_LAST) begin
                if (pkt_mode == MODE_FC)       st_nx = ST_EOFX;
                else if (pkt_mode == MODE_GBE) st_nx = ST_XIDLE;
                else                           st_nx = ST_IDLE;
            end
            ST_EOFX:   if (acc && cnt == EOF_LAST) st_nx = ST_IDLE;
            ST_XIDLE:  if (acc && in_k && in_data == K28_5) st_nx = ST_XIDLE2;
            ST_XIDLE2: if (acc) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_k     <= 1'b0;
            cnt       <= '0;
            held_d    <= '0;
            held_k    <= 1'b0;
            flip      <= 1'b0;
            pkt_mode  <= MODE_USER;
        end else begin
            if (crc_init) pkt_mode <= mode_i;
            case (st)
                ST_IDLE:  if (acc && start_det) cnt <= CNT_W'(PRE_LEN);
                ST_FCSOF: if (acc) cnt <= CNT_W'(FC_SOF_REST);
                ST_HDR:   if (acc) cnt <= cnt - 1'b1;
                ST_BODY: if (acc && end_det) begin
                    held_d <= in_data;
                    held_k <= in_k;
                    cnt    <= '0;
                end
                ST_CRC: if (adv) begin
                    if (cnt == CRC_LAST) begin
                        cnt  <= '0;
                        flip <= rd_pos_i;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_EOFX:  if (acc) cnt <= cnt + 1'b1;
                ST_XIDLE: if (acc && in_k && in_data == K28_5) flip <= rd_pos_i;
                default: ;
            endcase
            if (adv) begin
                if (st == ST_CRC) begin
                    out_valid <= 1'b1;
                    if (cnt == CRC_LAST) begin
                        out_data <= held_d;
                        out_k    <= held_k;
                    end else begin
                        out_data <= crc_byte;
                        out_k    <= 1'b0;
                    end
                end else if (acc && !(st == ST_BODY && end_det)) begin
                    out_valid <= 1'b1;
                    out_data  <= fix_d;
                    out_k     <= in_k;
                end else begin
                    out_valid <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/crcins_chk.sv
module crcins_chk
    import crcins_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input state_e      st,
    input logic [1:0]  pkt_mode,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic        out_k,
    input logic [31:0] crc_q
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_k)));

    assert_crc_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(crc_q));

    assert_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CRC) |-> !in_ready);

    assert_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(pkt_mode));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && st == ST_IDLE) |=> out_valid);
endmodule

bind crcins_top crcins_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .pkt_mode(pkt_mode),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_k(out_k), .crc_q(crc_q)
);

// File: tb/crcins_top_tb.sv
`timescale 1ns/1ps
module crcins_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       rd_pos_i = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_k = 1'b0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic       out_ready = 1'b1;
    logic       in_ready, out_valid, out_k;
    logic [7:0] out_data;

    int         checks = 0;
    int         errors = 0;
    logic [8:0] exp_q[$];
    logic [7:0] body[$];
    string      cur_req = "R1";
    bit         bp_on = 1'b0;

    always #4 clk = ~clk;

    crcins_top u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_pos_i(rd_pos_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_k(in_k),
        .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_k(out_k)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (body[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ body[i][b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    task automatic push(input logic [7:0] d, input logic k);
        exp_q.push_back({k, d});
    endtask

    task automatic push_body();
        foreach (body[i]) push(body[i], 1'b0);
    endtask

    task automatic push_crc();
        logic [31:0] x;
        x = ~ref_crc();
        for (int i = 0; i < 4; i++) push(x[8*i +: 8], 1'b0);
    endtask

    task automatic fill(input int len);
        body.delete();
        repeat (len) body.push_back(8'($urandom_range(0, 255)));
    endtask

    task automatic send(input logic [7:0] d, input logic k, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_k = k; in_sop = s; in_eop = e;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic send_body();
        foreach (body[i]) send(body[i], 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_k = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        #3;
        check(cur_req, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    // user-mode packet: sop byte, payload, CRC, eop byte
    task automatic pkt_user(input string req, input int len, input bit swap, input bit keep);
        cur_req = req; mode_i = 2'd0; rd_pos_i = 1'b1;
        if (!keep) fill(len);
        push(8'hA5, 1'b0); push_body(); push_crc(); push(8'h5A, 1'b0);
        send(8'hA5, 1'b0, 1'b1, 1'b0);
        if (swap) begin
            idle_in();
            mode_i = 2'd2;
        end
        send_body();
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        idle_in();
        drain();
        mode_i = 2'd0;
    endtask

    task automatic pkt_fc(input string req, input int len, input logic [7:0] d2, input bit rd);
        logic [7:0] d2x;
        cur_req = req; mode_i = 2'd1; rd_pos_i = rd;
        fill(len);
        d2x = !rd ? d2 : (d2 == 8'h95 ? 8'hB5 : 8'hAA);
        push(8'hBC, 1'b1); push(8'h95, 1'b0); push(8'hB5, 1'b0); push(8'hB5, 1'b0);
        push(8'hBC, 1'b1); push(8'hB5, 1'b0); push(8'h56, 1'b0); push(8'h56, 1'b0);
        push_body(); push_crc();
        push(8'hBC, 1'b1); push(d2x, 1'b0); push(8'h75, 1'b0); push(8'h75, 1'b0);
        send(8'hBC, 1'b1, 1'b0, 1'b0); send(8'h95, 1'b0, 1'b0, 1'b0);
        send(8'hB5, 1'b0, 1'b0, 1'b0); send(8'hB5, 1'b0, 1'b0, 1'b0);
        send(8'hBC, 1'b1, 1'b0, 1'b0); send(8'hB5, 1'b0, 1'b0, 1'b0);
        send(8'h56, 1'b0, 1'b0, 1'b0); send(8'h56, 1'b0, 1'b0, 1'b0);
        send_body();
        send(8'hBC, 1'b1, 1'b0, 1'b0); send(d2, 1'b0, 1'b0, 1'b0);
        send(8'h75, 1'b0, 1'b0, 1'b0); send(8'h75, 1'b0, 1'b0, 1'b0);
        idle_in();
        drain();
    endtask

    task automatic pkt_gbe(input string req, input int len, input bit rd, input int n_ext);
        cur_req = req; mode_i = 2'd2; rd_pos_i = rd;
        fill(len);
        push(8'hFB, 1'b1);
        repeat (6) push(8'h55, 1'b0);
        push(8'hD5, 1'b0);
        push_body(); push_crc();
        push(8'hFD, 1'b1);
        repeat (n_ext) push(8'hF7, 1'b1);
        push(8'hBC, 1'b1); push(rd ? 8'hC5 : 8'h50, 1'b0);
        push(8'hBC, 1'b1); push(8'h50, 1'b0);
        send(8'hFB, 1'b1, 1'b0, 1'b0);
        repeat (6) send(8'h55, 1'b0, 1'b0, 1'b0);
        send(8'hD5, 1'b0, 1'b0, 1'b0);
        send_body();
        send(8'hFD, 1'b1, 1'b0, 1'b0);
        repeat (n_ext) send(8'hF7, 1'b1, 1'b0, 1'b0);
        send(8'hBC, 1'b1, 1'b0, 1'b0); send(8'h50, 1'b0, 1'b0, 1'b0);
        send(8'hBC, 1'b1, 1'b0, 1'b0); send(8'h50, 1'b0, 1'b0, 1'b0);
        idle_in();
        drain();
    endtask

    // back-pressure driver
    initial begin
        forever begin
            @(negedge clk);
            out_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
        end
    end

    // reference comparison on every transfer
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(cur_req, {23'd0, out_k, out_data}, 32'hFFFFFFFF);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check(cur_req, {23'd0, out_k, out_data}, {23'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 32'(out_valid), 32'd0);
        check("R1", 32'(in_ready), 32'd1);

        // R3: reference CRC against the nine-digit check value
        body.delete();
        for (int i = 0; i < 9; i++) body.push_back(8'h31 + 8'(i));
        check("R3", ~ref_crc(), 32'hCBF43926);
        pkt_user("R3", 9, 1'b0, 1'b1);

        // R10: pass-through byte visible one cycle after acceptance
        cur_req = "R10";
        push(8'h3C, 1'b0);
        send(8'h3C, 1'b0, 1'b0, 1'b0);
        idle_in();
        #2;
        check("R10", {23'd0, out_valid, out_data}, {23'd0, 1'b1, 8'h3C});
        drain();

        pkt_user("R4", 0, 1'b0, 1'b0);
        pkt_user("R4", 1, 1'b0, 1'b0);
        pkt_user("R4", 20, 1'b0, 1'b0);

        bp_on = 1'b1;
        pkt_user("R2", 30, 1'b0, 1'b0);
        pkt_user("R9", 12, 1'b1, 1'b0);

        pkt_fc("R5", 10, 8'h95, 1'b0);
        pkt_fc("R6", 7, 8'h95, 1'b1);
        pkt_fc("R6", 5, 8'h8A, 1'b1);
        pkt_fc("R5", 3, 8'h8A, 1'b0);

        pkt_gbe("R7", 16, 1'b0, 0);
        pkt_gbe("R8", 9, 1'b1, 2);
        bp_on = 1'b0;
        pkt_gbe("R7", 1, 1'b0, 1);

        cur_req = "R2";
        repeat (10) @(negedge clk);
        check("R2", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end
endmodule